// File: doc/BRIEF.md
# Load-Link/Store-Conditional Exclusive Monitor

This block sits between two to four cores and a shared word memory that is modelled as a register array. Each core can send four kinds of request: a plain load, a plain store, a load-link or a store-conditional. Every request carries a word address and write data. A round-robin arbiter takes at most one request per cycle. The accepted request then reads the memory, may write it, and updates a table that holds one reservation per core. One cycle later the requesting core receives a response that holds the memory word as it stood before the access and, for a store-conditional, a success flag.

A reservation records only that a core has a claim on an address. It never records the value that was read. Any write that lands on a reserved address breaks that reservation. A location that is written to a new value and then written back to its old value has therefore still been disturbed, and a later store-conditional to it fails. Store-conditionals that compete for the same address are serialised by the arbiter. The first one that holds a valid reservation wins, and its write removes every other core's claim on that address.

Top module: `llsc_monitor`

## Requirements
- R1: The arbiter grants at most one core per cycle and only a core whose req_valid is high. It searches round-robin, starting at the core after the last granted one. Core 0 is searched first after reset.
- R2: A request granted in cycle n gets its response in cycle n+1 on that core's rsp_valid bit, and only on that bit.
- R3: A load or load-link returns, on rsp_rdata, the memory word at the request address. A load-link also makes the requesting core's reservation valid on that address.
- R4: A plain store writes its data to memory. It clears every valid reservation on that address, including the storing core's own reservation.
- R5: A store-conditional writes its data and reports rsp_sc_ok = 1 only when the requester holds a valid reservation on the same address. rsp_sc_ok is 0 for every other response.
- R6: A store-conditional issued with no valid reservation, or issued to a different address than the reserved one, reports failure and leaves memory unchanged.
- R7: A store-conditional clears the requester's reservation, whether it succeeds or fails.
- R8: When several cores store-conditionally write an address they all reserved, exactly one succeeds. The successful write clears the other cores' reservations on that address.
- R9: If another core stores a different value and then stores the original value back after a load-link, the following store-conditional fails.
- R10: A new load-link replaces the core's earlier reservation, so a store-conditional to the old address fails.
- R11: While reset is held, no grant and no response is given. After reset the memory reads zero and no reservation is valid.
- R12: rsp_rdata always carries the word as it was before the access, for stores and store-conditionals too. Opcode encoding: 00 load, 01 store, 10 load-link, 11 store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_CORES | One request-pending bit per core, held until granted |
| req_op | input | 2*NUM_CORES | Opcode per core, core i at bits [2i+1:2i] |
| req_addr | input | ADDR_W*NUM_CORES | Word address per core |
| req_wdata | input | DATA_W*NUM_CORES | Write data per core |
| req_grant | output | NUM_CORES | One-hot grant; the request is taken at this clock edge |
| rsp_valid | output | NUM_CORES | One-hot response strobe, one cycle after the grant |
| rsp_rdata | output | DATA_W | Memory word before the access |
| rsp_sc_ok | output | 1 | Store-conditional success flag |

## Verification
The grant settles combinationally in the cycle in which a request is presented. The bench therefore reads it one nanosecond after driving at the falling edge, and compares it with its own round-robin pointer. A granted request is taken at the next rising edge. Its response is due exactly one cycle later, so each scoreboard entry stores the cycle number at which it is due. The monitor compares strobe, data and success flag at the falling edge of that cycle, and reports an early, late or unexpected response as a failure of R2.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
// Shared opcode type for the exclusive monitor.
// Assumes the two-bit encoding is fixed at the core ports.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_rr_arbiter.sv
`timescale 1ns/1ps
// Round-robin arbiter: picks one requester per cycle, searching from the
// core after the last winner. Assumes requests stay asserted until granted.
// Grants are forced low while reset is held.
module llsc_rr_arbiter #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] ptr;
    logic             found;
    int               cand;

    // Search for the first requester in rotated order starting at ptr.
    always_comb begin
        grant   = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = 0;
        for (int off = 0; off < N; off++) begin
            cand = int'(ptr) + off;
            if (cand >= N) cand = cand - N;
            if (!found && rst_n && req[cand]) begin
                found       = 1'b1;
                grant[cand] = 1'b1;
                gnt_idx     = IDX_W'(cand);
            end
        end
    end

    // Advance the search start past the core that just won.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/llsc_resv_table.sv
`timescale 1ns/1ps
// Reservation table: one valid bit and one word address per core.
// Sets an entry on a load-link, and clears it on the core's own
// store-conditional, on its own store to the address, or on any memory
// write that another core makes to the address.
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc,
    input  logic [IDX_W-1:0]    core_idx,
    input  llsc_op_e            op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                mem_we,
    output logic                sc_pass,
    output logic [N-1:0]        resv_valid,
    output logic [N*ADDR_W-1:0] resv_addr
);
    logic [ADDR_W-1:0] entry_addr [N];

    // Decide whether the requester still holds a reservation on addr.
    always_comb begin
        sc_pass = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == core_idx && resv_valid[i] && entry_addr[i] == addr)
                sc_pass = 1'b1;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        // Update one core's reservation from the accepted request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resv_valid[g] <= 1'b0;
                entry_addr[g] <= '0;
            end else if (acc && core_idx == IDX_W'(g)) begin
                case (op)
                    OP_LINK: begin
                        resv_valid[g] <= 1'b1;
                        entry_addr[g] <= addr;
                    end
                    OP_COND:  resv_valid[g] <= 1'b0;
                    OP_STORE: if (entry_addr[g] == addr) resv_valid[g] <= 1'b0;
                    default:  ;
                endcase
            end else if (mem_we && resv_valid[g] && entry_addr[g] == addr) begin
                resv_valid[g] <= 1'b0;
            end
        end
        assign resv_addr[g*ADDR_W +: ADDR_W] = entry_addr[g];
    end
endmodule

// File: rtl/llsc_word_mem.sv
`timescale 1ns/1ps
// Single-ported word memory held in registers. Reads are combinational
// and return the word before any write of the same cycle. Cleared to zero
// by reset.
module llsc_word_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    // Present the addressed word.
    assign rdata = words[addr];

    // Clear on reset, otherwise write the addressed word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
// Exclusive monitor top. It arbitrates the core requests, applies the
// winning one to memory and the reservation table, and registers a
// one-cycle response to the winner. It assumes each core holds its request
// until it sees its grant bit.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [2*NUM_CORES-1:0]      req_op,
    input  logic [ADDR_W*NUM_CORES-1:0] req_addr,
    input  logic [DATA_W*NUM_CORES-1:0] req_wdata,
    output logic [NUM_CORES-1:0]        req_grant,
    output logic [NUM_CORES-1:0]        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_sc_ok
);
    logic [IDX_W-1:0]            gnt_idx;
    logic                        acc;
    llsc_op_e                    sel_op;
    logic [ADDR_W-1:0]           sel_addr;
    logic [DATA_W-1:0]           sel_wdata;
    logic                        sc_pass;
    logic                        mem_we;
    logic [DATA_W-1:0]           mem_rdata;
    logic [NUM_CORES-1:0]        resv_valid;
    logic [NUM_CORES*ADDR_W-1:0] resv_addr;

    llsc_rr_arbiter #(.N(NUM_CORES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .grant   (req_grant),
        .gnt_idx (gnt_idx)
    );

    assign acc = |req_grant;

    // Route the winning core's request fields to the shared datapath.
    always_comb begin
        sel_op    = OP_LOAD;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (IDX_W'(i) == gnt_idx) begin
                sel_op    = llsc_op_e'(req_op[2*i +: 2]);
                sel_addr  = req_addr[ADDR_W*i +: ADDR_W];
                sel_wdata = req_wdata[DATA_W*i +: DATA_W];
            end
        end
    end

    // A store always writes; a store-conditional writes only with its reservation intact.
    assign mem_we = acc && (sel_op == OP_STORE || (sel_op == OP_COND && sc_pass));

    llsc_resv_table #(.N(NUM_CORES), .ADDR_W(ADDR_W)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .core_idx   (gnt_idx),
        .op         (sel_op),
        .addr       (sel_addr),
        .mem_we     (mem_we),
        .sc_pass    (sc_pass),
        .resv_valid (resv_valid),
        .resv_addr  (resv_addr)
    );

    llsc_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_rdata)
    );

    // Register the response for the core that was served this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= req_grant;
            rsp_rdata <= acc ? mem_rdata : rsp_rdata;
            rsp_sc_ok <= acc && sel_op == OP_COND && sc_pass;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
// Property checker for the exclusive monitor, bound to every instance.
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CORES-1:0]        req_valid,
    input logic [NUM_CORES-1:0]        req_grant,
    input logic [NUM_CORES-1:0]        rsp_valid,
    input logic                        rsp_sc_ok,
    input logic                        acc,
    input logic [1:0]                  sel_op,
    input logic [ADDR_W-1:0]           sel_addr,
    input logic [NUM_CORES-1:0]        resv_valid,
    input logic [NUM_CORES*ADDR_W-1:0] resv_addr
);
    logic [ADDR_W-1:0] last_addr;
    logic              hit_any;

    // Remember the address served in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_addr <= '0;
        else        last_addr <= sel_addr;
    end

    // Flag whether any core still holds a reservation on that address.
    always_comb begin
        hit_any = 1'b0;
        for (int i = 0; i < NUM_CORES; i++)
            if (resv_valid[i] && resv_addr[i*ADDR_W +: ADDR_W] == last_addr) hit_any = 1'b1;
    end

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant));
    p_grant_requested_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant & ~req_valid) == '0);
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_grant & req_valid));
    p_rsp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    p_ok_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> (rsp_valid != '0));
    p_nores_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_op == OP_COND && (resv_valid & req_grant) == '0) |=> !rsp_sc_ok);
    p_sc_drops_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_op == OP_COND) |=> ((resv_valid & $past(req_grant)) == '0));
    p_winner_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> !hit_any);
    p_store_breaks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_op == OP_STORE) |=> !hit_any);
    p_link_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sel_op == OP_LINK) |=> ((resv_valid & $past(req_grant)) == $past(req_grant)));
endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_grant  (req_grant),
    .rsp_valid  (rsp_valid),
    .rsp_sc_ok  (rsp_sc_ok),
    .acc        (acc),
    .sel_op     (sel_op),
    .sel_addr   (sel_addr),
    .resv_valid (resv_valid),
    .resv_addr  (resv_addr)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
    localparam int NC = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_valid = '0;
    logic [2*NC-1:0]   req_op = '0;
    logic [AW*NC-1:0]  req_addr = '0;
    logic [DW*NC-1:0]  req_wdata = '0;
    logic [NC-1:0]     req_grant;
    logic [NC-1:0]     rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_sc_ok;

    llsc_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0, wins = 0;
    bit done = 0;

    // Pending requests per core and the reference model state.
    bit          pv [NC];
    logic [1:0]  pop [NC];
    int          pa [NC];
    logic [DW-1:0] pw [NC];
    string       ptag [NC];
    logic [DW-1:0] m_mem [1<<AW];
    bit          rv [NC];
    int          ra [NC];
    int          rrp = 0;

    // Scoreboard queues.
    int            q_core [$];
    logic [DW-1:0] q_rd [$];
    bit            q_ok [$];
    int            q_due [$];
    string         q_tag [$];

    task automatic chk(bit cond, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: pop expected responses and compare at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid != '0) begin
                if (q_core.size() == 0) begin
                    chk(0, "R2", "unexpected response", DW'(rsp_valid), 0);
                end else begin
                    int c; logic [DW-1:0] rd; bit ok; int due; string tg;
                    c = q_core.pop_front(); rd = q_rd.pop_front(); ok = q_ok.pop_front();
                    due = q_due.pop_front(); tg = q_tag.pop_front();
                    chk(rsp_valid == NC'(1 << c), "R2", "response strobe", DW'(rsp_valid), DW'(1 << c));
                    chk(cyc == due, "R2", "response cycle", DW'(cyc), DW'(due));
                    chk(rsp_rdata == rd, tg, "read data", rsp_rdata, rd);
                    chk(rsp_sc_ok == ok, tg, "sc status", DW'(rsp_sc_ok), DW'(ok));
                    if (tg == "R8" && rsp_sc_ok) wins++;
                end
            end else if (q_core.size() != 0 && cyc > q_due[0]) begin
                chk(0, "R2", "missing response", 0, 1);
                void'(q_core.pop_front()); void'(q_rd.pop_front()); void'(q_ok.pop_front());
                void'(q_due.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    // Apply one accepted request to the reference model and queue its result.
    task automatic accept(int c);
        int a; logic [DW-1:0] old; bit ok;
        a = pa[c]; old = m_mem[a]; ok = 0;
        case (pop[c])
            LL: begin rv[c] = 1; ra[c] = a; end
            ST: begin
                m_mem[a] = pw[c];
                for (int k = 0; k < NC; k++) if (rv[k] && ra[k] == a) rv[k] = 0;
            end
            SC: begin
                if (rv[c] && ra[c] == a) begin
                    ok = 1; m_mem[a] = pw[c];
                    for (int k = 0; k < NC; k++) if (rv[k] && ra[k] == a) rv[k] = 0;
                end
                rv[c] = 0;
            end
            default: ;
        endcase
        q_core.push_back(c); q_rd.push_back(old); q_ok.push_back(ok);
        q_due.push_back(cyc + 1); q_tag.push_back(ptag[c]);
    endtask

    // Driver: one cycle of stimulus, grant check, and model update.
    task automatic step();
        int eg; bit any;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            req_valid[c] = pv[c];
            req_op[2*c +: 2] = pop[c];
            req_addr[AW*c +: AW] = AW'(pa[c]);
            req_wdata[DW*c +: DW] = pw[c];
        end
        #1;
        eg = -1; any = 0;
        for (int off = 0; off < NC; off++) begin
            int cand; cand = (rrp + off) % NC;
            if (pv[cand]) any = 1;
            if (eg < 0 && pv[cand]) eg = cand;
        end
        if (any) chk(req_grant == NC'(1 << eg), "R1", "round-robin grant", DW'(req_grant), DW'(1 << eg));
        if (eg >= 0) begin
            accept(eg);
            rrp = (eg + 1) % NC;
            pv[eg] = 0;
        end
    endtask

    task automatic post(int c, logic [1:0] op, int a, logic [DW-1:0] wd, string tag);
        pv[c] = 1; pop[c] = op; pa[c] = a; pw[c] = wd; ptag[c] = tag;
    endtask

    task automatic settle();
        bit busy;
        busy = 1;
        while (busy) begin
            busy = 0;
            for (int c = 0; c < NC; c++) if (pv[c]) busy = 1;
            if (busy) step();
        end
        repeat (3) step();
    endtask

    task automatic one(int c, logic [1:0] op, int a, logic [DW-1:0] wd, string tag);
        post(c, op, a, wd, tag);
        settle();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin pv[c] = 0; pop[c] = LD; pa[c] = 0; pw[c] = 0; rv[c] = 0; ra[c] = 0; ptag[c] = ""; end
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;

        // R11: requests presented during reset are neither granted nor answered.
        req_valid = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_grant == '0, "R11", "grant in reset", DW'(req_grant), 0);
        chk(rsp_valid == '0, "R11", "response in reset", DW'(rsp_valid), 0);
        req_valid = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == '0, "R11", "response after reset", DW'(rsp_valid), 0);
        one(2, LD, 5, 0, "R11");

        // R3, R4, R12: store then load from another core.
        one(0, ST, 5, 32'hA5A5_0001, "R12");
        one(1, LD, 5, 0, "R3");

        // R5: load-link then store-conditional succeeds and writes.
        one(0, LL, 7, 0, "R3");
        one(0, SC, 7, 32'h11, "R5");
        one(3, LD, 7, 0, "R5");

        // R7: a second store-conditional without a new link fails.
        one(0, SC, 7, 32'h22, "R7");
        one(3, LD, 7, 0, "R7");

        // R6: no reservation, and a mismatched address, both fail without writing.
        one(1, SC, 8, 32'h33, "R6");
        one(1, LD, 8, 0, "R6");
        one(1, LL, 9, 0, "R6");
        one(1, SC, 10, 32'h44, "R6");
        one(2, LD, 10, 0, "R6");

        // R9: value changed and changed back still breaks the reservation.
        one(2, ST, 16, 32'h1, "R9");
        one(0, LL, 16, 0, "R9");
        one(1, ST, 16, 32'h2, "R9");
        one(1, ST, 16, 32'h1, "R9");
        one(0, SC, 16, 32'h99, "R9");
        one(3, LD, 16, 0, "R9");

        // R4: a core's own store breaks its reservation.
        one(2, LL, 12, 0, "R4");
        one(2, ST, 12, 32'h55, "R4");
        one(2, SC, 12, 32'h66, "R4");

        // Store to a neighbouring address leaves a reservation intact.
        one(0, LL, 40, 0, "R5");
        one(1, ST, 41, 32'h77, "R5");
        one(0, SC, 40, 32'h88, "R5");

        // R10: a new link replaces the old one.
        one(3, LL, 20, 0, "R10");
        one(3, LL, 21, 0, "R10");
        one(3, SC, 20, 32'hAA, "R10");
        one(3, LL, 21, 0, "R10");
        one(3, SC, 21, 32'hBB, "R10");
        one(0, LD, 21, 0, "R10");

        // R8: four cores reserve one address and race their store-conditionals.
        for (int c = 0; c < NC; c++) one(c, LL, 30, 0, "R8");
        wins = 0;
        for (int c = 0; c < NC; c++) post(c, SC, 30, DW'(32'hC0 + c), "R8");
        settle();
        chk(wins == 1, "R8", "store-conditional winners", DW'(wins), 1);
        one(1, LD, 30, 0, "R8");

        // R1: overlapping request sets exercise the rotation.
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < NC; c++) post(c, LD, c + r, 0, "R1");
            settle();
        end
        post(1, LD, 2, 0, "R1"); post(3, ST, 3, 32'h5, "R1");
        settle();
        post(0, LD, 3, 0, "R1"); post(2, LD, 5, 0, "R1"); post(3, LD, 7, 0, "R1");
        settle();

        chk(q_core.size() == 0, "R2", "leftover expected responses", DW'(q_core.size()), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule